// File: doc/BRIEF.md
# Compatibility-Mode Printer Port Register Block

This block is the host-side register file of a byte-wide printer port in standard compatibility mode. A simple synchronous bus with an address, a write strobe and a read strobe reaches three registers: data, status and control. The printer handshake is modelled inside the block, so no cable or printer is needed.

Software puts a byte in the data register and then writes the control register. When the control write completes a strobe with init and select held high, the byte goes out on a byte stream, marked by a one-cycle valid pulse. After that, successive status reads step the acknowledge and busy bits the way a printer would answer.

When interrupt enable is on, the strobe-release control pattern arms a level interrupt. The next status read clears it. A data read returns either the last byte written or an input latch, depending on the direction bit. The input latch follows the port input pins while the direction is set to input.

Top module: `lpt_compat_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0xD9 and a control read returns 0xCC. The irq and out_valid outputs are 0.
- R2: Only address bits [2:0] are decoded: 0 selects data, 1 selects status and 2 selects control. A read of offsets 3 to 7 returns 0xFF. Writes to offset 1 or to offsets 3 to 7 change no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and a control read returns that stored value.
- R4: A control write with bit 2 (init) equal to 0 loads the status register with 0xD8.
- R5: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all 1 clears status bit 7. If the stored strobe bit was 0 before that write, out_byte carries the data-out byte and out_valid is 1 for exactly one cycle, starting in the cycle after the write.
- R6: A control write with init and select set and strobe clear sets the interrupt-pending flag if the stored control bit 4 (interrupt enable) was already 1. The irq output equals that flag in the cycle after the write.
- R7: A status read returns the current status and clears the interrupt-pending flag, so irq is 0 in the cycle after the read.
- R8: Status bit 7 is inverted busy and bit 6 is acknowledge. After a status read, if bit 7 was 0 and the stored strobe bit is 0, the status changes: bit 6 is cleared if it was set, and otherwise bits 6 and 7 are both set. In any other case the read leaves the status unchanged.
- R9: A data read returns the input latch when control bit 5 (direction) is 1, and the data-out latch otherwise. The input latch samples pin_din on every clock while the direction bit is 1.
- R10: Read data is registered and appears on rdata in the cycle after rd_en. rdata holds its value when there is no read. When wr_en and rd_en are high together, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address; only bits [2:0] are decoded |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_din | input | 8 | Port data pins, sampled while direction is input |
| out_byte | output | 8 | Byte emitted by a strobe |
| out_valid | output | 1 | One-cycle marker for out_byte |
| irq | output | 1 | Level interrupt, equals the pending flag |

## Verification
The bench builds the block with ADDR_W set to 4, so the addresses include a fourth bit that must be ignored. Offsets 8 to 15 must therefore alias offsets 0 to 7, which a 3-bit address could not show. With this width, a sweep reads every address and checks both real and aliased decodes. A second sweep writes all 256 control values and reads each one back through an alternating alias. Directed sequences then follow the whole handshake cycle through status reads, interrupt arming and clearing, the direction switch, and collisions between a write and a read.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int BYTE_W = 8;

    // status bit positions
    localparam int ST_NBUSY = 7;
    localparam int ST_ACK   = 6;

    // control bit positions
    localparam int CT_DIR   = 5;
    localparam int CT_IEN   = 4;
    localparam int CT_SEL   = 3;
    localparam int CT_INIT  = 2;
    localparam int CT_STB   = 0;

    localparam logic [BYTE_W-1:0] CTRL_FIXED   = 8'hC0;
    localparam logic [BYTE_W-1:0] STAT_RESET   = 8'hD9;
    localparam logic [BYTE_W-1:0] STAT_INITLOW = 8'hD8;
    localparam logic [BYTE_W-1:0] CTRL_RESET   = 8'hCC;
    localparam logic [BYTE_W-1:0] DATA_RESET   = 8'hFF;
    localparam logic [BYTE_W-1:0] OPEN_READ    = 8'hFF;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dout;
        logic [BYTE_W-1:0] din;
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] ctrl;
        logic              irq;
        logic [BYTE_W-1:0] rd;
        logic [BYTE_W-1:0] obyte;
        logic              ovalid;
    } port_regs_t;

endpackage

// File: rtl/lpt_addr_decode.sv
module lpt_addr_decode
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int DEC_W = 3;

    logic [DEC_W-1:0] low_bits;

    generate
        if (ADDR_W > DEC_W) begin : g_wide
            logic unused_hi_bits;
            assign unused_hi_bits = ^addr[ADDR_W-1:DEC_W];
            assign low_bits = addr[DEC_W-1:0];
        end else if (ADDR_W == DEC_W) begin : g_exact
            assign low_bits = addr;
        end else begin : g_narrow
            assign low_bits = {{(DEC_W-ADDR_W){1'b0}}, addr};
        end
    endgenerate

    always_comb begin
        case (low_bits)
            3'd0:    sel = SEL_DATA;
            3'd1:    sel = SEL_STAT;
            3'd2:    sel = SEL_CTRL;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/lpt_ctrl_write.sv
module lpt_ctrl_write
    import lpt_pkg::*;
(
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] stat_q,
    input  logic              prev_strobe,
    input  logic              prev_ien,
    output logic [BYTE_W-1:0] ctrl_d,
    output logic [BYTE_W-1:0] stat_d,
    output logic              emit,
    output logic              irq_set
);

    always_comb begin
        ctrl_d  = wdata | CTRL_FIXED;
        stat_d  = stat_q;
        emit    = 1'b0;
        irq_set = 1'b0;
        if (!ctrl_d[CT_INIT]) begin
            stat_d = STAT_INITLOW;
        end else if (ctrl_d[CT_SEL]) begin
            if (ctrl_d[CT_STB]) begin
                stat_d[ST_NBUSY] = 1'b0;
                emit             = !prev_strobe;
            end else begin
                irq_set = prev_ien;
            end
        end
    end

endmodule

// File: rtl/lpt_status_step.sv
module lpt_status_step
    import lpt_pkg::*;
(
    input  logic [BYTE_W-1:0] stat_q,
    input  logic              prev_strobe,
    output logic [BYTE_W-1:0] stat_d
);

    always_comb begin
        stat_d = stat_q;
        if (!stat_q[ST_NBUSY] && !prev_strobe) begin
            if (stat_q[ST_ACK]) begin
                stat_d[ST_ACK] = 1'b0;
            end else begin
                stat_d[ST_ACK]   = 1'b1;
                stat_d[ST_NBUSY] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lpt_compat_regs.sv
module lpt_compat_regs
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        pin_din,
    output logic [7:0]        out_byte,
    output logic              out_valid,
    output logic              irq
);

    port_regs_t regs_q, regs_d;
    reg_sel_e   sel;

    logic [BYTE_W-1:0] cw_ctrl;
    logic [BYTE_W-1:0] cw_stat;
    logic              cw_emit;
    logic              cw_irq;
    logic [BYTE_W-1:0] step_stat;

    lpt_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    lpt_ctrl_write u_cw (
        .wdata       (wdata),
        .stat_q      (regs_q.stat),
        .prev_strobe (regs_q.ctrl[CT_STB]),
        .prev_ien    (regs_q.ctrl[CT_IEN]),
        .ctrl_d      (cw_ctrl),
        .stat_d      (cw_stat),
        .emit        (cw_emit),
        .irq_set     (cw_irq)
    );

    lpt_status_step u_step (
        .stat_q      (regs_q.stat),
        .prev_strobe (regs_q.ctrl[CT_STB]),
        .stat_d      (step_stat)
    );

    always_comb begin
        regs_d        = regs_q;
        regs_d.ovalid = 1'b0;
        if (regs_q.ctrl[CT_DIR]) begin
            regs_d.din = pin_din;
        end
        if (wr_en) begin
            case (sel)
                SEL_DATA: regs_d.dout = wdata;
                SEL_CTRL: begin
                    regs_d.ctrl = cw_ctrl;
                    regs_d.stat = cw_stat;
                    if (cw_emit) begin
                        regs_d.ovalid = 1'b1;
                        regs_d.obyte  = regs_q.dout;
                    end
                    if (cw_irq) begin
                        regs_d.irq = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (rd_en) begin
            case (sel)
                SEL_DATA: regs_d.rd = regs_q.ctrl[CT_DIR] ? regs_q.din : regs_q.dout;
                SEL_STAT: begin
                    regs_d.rd   = regs_q.stat;
                    regs_d.irq  = 1'b0;
                    regs_d.stat = step_stat;
                end
                SEL_CTRL: regs_d.rd = regs_q.ctrl;
                default:  regs_d.rd = OPEN_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dout   <= DATA_RESET;
            regs_q.din    <= DATA_RESET;
            regs_q.stat   <= STAT_RESET;
            regs_q.ctrl   <= CTRL_RESET;
            regs_q.irq    <= 1'b0;
            regs_q.rd     <= '0;
            regs_q.obyte  <= '0;
            regs_q.ovalid <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata     = regs_q.rd;
    assign out_byte  = regs_q.obyte;
    assign out_valid = regs_q.ovalid;
    assign irq       = regs_q.irq;

endmodule

// File: rtl/lpt_compat_regs_chk.sv
module lpt_compat_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr_lo,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       out_valid,
    input logic       irq
);

    assert_open_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr_lo > 3'd2) |=> (rdata == 8'hFF));

    assert_ctrl_high_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr_lo == 3'd2) |=> (rdata[7:6] == 2'b11));

    assert_emit_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(wr_en && addr_lo == 3'd2 && wdata[0] && wdata[2] && wdata[3]));

    assert_emit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_irq_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en && addr_lo == 3'd2 && !wdata[0]));

    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr_lo == 3'd1) |=> !irq);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rdata));

endmodule

bind lpt_compat_regs lpt_compat_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_lo   (addr[2:0]),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .out_valid (out_valid),
    .irq       (irq)
);

// File: tb/tb_lpt_compat_regs.sv
module tb_lpt_compat_regs;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic [7:0]        pin_din = '0;
    logic [7:0]        out_byte;
    logic              out_valid;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] got;
    logic       ov_seen;
    logic [7:0] ob_seen;

    lpt_compat_regs #(.ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .pin_din   (pin_din),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        ov_seen = out_valid;
        ob_seen = out_byte;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic expect_read(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        do_read(a, v);
        check(v == e, req, v, e);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0x00 expected=0x01");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset values
        check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
        check(out_valid == 1'b0, "R1 out_valid", {7'd0, out_valid}, 8'h00);
        expect_read(4'd0, 8'hFF, "R1 data");
        expect_read(4'd1, 8'hD9, "R1 status");
        expect_read(4'd2, 8'hCC, "R1 control");

        // R2 sweep every address: offsets 3..7 and aliases open
        for (int a = 0; a < 16; a++) begin
            logic [7:0] e;
            case (a % 8)
                0: e = 8'hFF;
                1: e = 8'hD9;
                2: e = 8'hCC;
                default: e = 8'hFF;
            endcase
            expect_read(a[ADDR_W-1:0], e, "R2 decode sweep");
        end
        do_write(4'd1, 8'h00);
        do_write(4'd5, 8'h00);
        do_write(4'd13, 8'h00);
        expect_read(4'd1, 8'hD9, "R2 status write ignored");
        expect_read(4'd2, 8'hCC, "R2 control untouched");
        expect_read(4'd0, 8'hFF, "R2 data untouched");

        // R3 sweep all control values, alternating alias address 10
        for (int v = 0; v < 256; v++) begin
            logic [ADDR_W-1:0] ca;
            ca = (v % 2 == 1) ? 4'd10 : 4'd2;
            do_write(ca, v[7:0]);
            expect_read(ca, v[7:0] | 8'hC0, "R3 control readback");
        end

        // R1 reset clears state left by the sweep
        do_reset();
        check(irq == 1'b0, "R1 irq after reset", {7'd0, irq}, 8'h00);
        expect_read(4'd2, 8'hCC, "R1 control after reset");

        // R5 strobe emission
        do_write(4'd0, 8'h5A);
        do_write(4'd2, 8'h0C);
        check(ov_seen == 1'b0, "R5 no emit without strobe", {7'd0, ov_seen}, 8'h00);
        do_write(4'd2, 8'h0D);
        check(ov_seen == 1'b1, "R5 emit valid", {7'd0, ov_seen}, 8'h01);
        check(ob_seen == 8'h5A, "R5 emit byte", ob_seen, 8'h5A);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 single pulse", {7'd0, out_valid}, 8'h00);
        expect_read(4'd1, 8'h59, "R5 busy cleared");
        do_write(4'd2, 8'h0D);
        check(ov_seen == 1'b0, "R5 no repeat while strobe held", {7'd0, ov_seen}, 8'h00);
        expect_read(4'd1, 8'h59, "R8 no step while strobe stored");

        // R8 handshake steps
        do_write(4'd2, 8'h0C);
        expect_read(4'd1, 8'h59, "R8 step 1");
        expect_read(4'd1, 8'h19, "R8 step 2 ack cleared");
        expect_read(4'd1, 8'hD9, "R8 step 3 ack and busy set");
        expect_read(4'd1, 8'hD9, "R8 stable when busy high");

        // R6 / R7 interrupt
        do_write(4'd2, 8'h1C);
        check(irq == 1'b0, "R6 needs stored enable", {7'd0, irq}, 8'h00);
        do_write(4'd2, 8'h1C);
        check(irq == 1'b1, "R6 irq armed", {7'd0, irq}, 8'h01);
        do_write(4'd2, 8'h1D);
        check(ov_seen == 1'b1 && ob_seen == 8'h5A, "R5 emit with irq", ob_seen, 8'h5A);
        check(irq == 1'b1, "R6 irq held", {7'd0, irq}, 8'h01);
        expect_read(4'd1, 8'h59, "R7 status value");
        check(irq == 1'b0, "R7 irq cleared", {7'd0, irq}, 8'h00);
        do_write(4'd2, 8'h14);
        do_write(4'd2, 8'h14);
        check(irq == 1'b0, "R6 no arm without select", {7'd0, irq}, 8'h00);

        // R4 init low
        do_write(4'd2, 8'h08);
        expect_read(4'd1, 8'hD8, "R4 status load");
        expect_read(4'd2, 8'hC8, "R4 control stored");

        // R9 direction select
        pin_din = 8'h3C;
        do_write(4'd0, 8'hA5);
        expect_read(4'd0, 8'hA5, "R9 output latch");
        do_write(4'd2, 8'h2C);
        check(ov_seen == 1'b0, "R9 dir write no emit", {7'd0, ov_seen}, 8'h00);
        expect_read(4'd0, 8'h3C, "R9 input latch");
        pin_din = 8'hC3;
        @(negedge clk);
        expect_read(4'd0, 8'hC3, "R9 input follows pins");
        do_write(4'd2, 8'h0C);
        expect_read(4'd0, 8'hA5, "R9 back to output latch");

        // R10 simultaneous write and read
        expect_read(4'd2, 8'hCC, "R10 setup");
        @(negedge clk);
        addr = 4'd2; wdata = 8'h04; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rdata == 8'hCC, "R10 read ignored", rdata, 8'hCC);
        @(negedge clk);
        check(rdata == 8'hCC, "R10 rdata held", rdata, 8'hCC);
        expect_read(4'd2, 8'hC4, "R10 write performed");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule